// File: doc/BRIEF.md
# Flash Access Security Level Gate

This block sits between a programming command decoder and the memory back end of an on-chip loader. It keeps a one-byte software protection level and, for every operation offered to it, decides at once whether the operation may go ahead. When it refuses an operation, it returns the error status code that the command decoder reports to the host. Operations are grouped into classes: memory array access, fuse bits, boot configuration bytes, the protection byte itself, identification data, block erase and blank check. Each class carries a read/write flag.

The protection level can only rise through writes to the protection byte. Only a full-erase pulse brings it back to the unprotected value. The block also holds three boot configuration bytes: a boot status byte, a boot vector byte and a spare byte. These can be read and written at every level. The full erase resets the first two of them together with the level.

Top module: `sec_gate`

## Requirements
- R1: After a synchronous reset the protection byte reads FFh, the boot status byte FFh, the boot vector byte FCh and the spare byte FFh. With `req_valid` low, `allow` is 0 and `status` is 00h.
- R2: The only legal protection levels are FFh (open), FEh (write-locked) and FCh (fully locked). A write to the protection byte (class 3) is accepted only if its value is legal and ranks strictly higher than the current level. Any other write is refused with status 03h and leaves the byte unchanged.
- R3: At FEh, a write to the memory array (class 0) or the fuse bits (class 1) is refused with 03h, and reads of those classes are allowed.
- R4: At FCh, a read of class 0 or 1 is refused with 0Bh and a write is refused with 03h.
- R5: Block erase (class 5) is allowed only at FFh. At any other level it is refused with 03h.
- R6: Blank check (class 6) and boot configuration access (class 2) are allowed at every level, whether read or write.
- R7: Identification data (class 4) can be read at every level. A write to it is always refused with 03h.
- R8: A full-erase pulse sets the protection byte, the boot status byte and the boot vector byte to FFh at the next clock edge. The spare byte keeps its value. The erase takes priority over a write to any of those bytes in the same cycle.
- R9: A read of class 3 returns the protection byte on `rdata`. A read of class 2 returns the byte picked by `req_sel`: 0 for boot status, 1 for boot vector, 2 for spare. `req_sel` = 3 is refused with 08h.
- R10: Class 7 is reserved and is refused with 0Eh.
- R11: `allow` and `status` depend combinationally on the request. An allowed write updates storage at the next clock edge. A refused write changes nothing. Every allowed operation reports 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation offered this cycle |
| req_class | input | 3 | Operation class code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Boot configuration byte select |
| req_wdata | input | 8 | Write value for the protection or configuration byte |
| erase_all | input | 1 | Full-erase pulse |
| allow | output | 1 | Operation may proceed |
| status | output | 8 | 00h when allowed, error code when refused |
| rdata | output | 8 | Read value for classes 2 and 3 |

## Verification
A full-erase pulse and an allowed write to a stored byte can arrive in the same cycle. The bench provokes this in three ways, each in a single cycle:
- Raising the protection byte while erasing. The byte is then judged to read FFh.
- Writing the boot vector while erasing. It is judged to read FFh.
- Writing the spare byte while erasing. It is judged to keep the new value, because the erase does not reach that byte.

The permission matrix is swept at each of the three levels, together with the illegal and lowering writes to the protection byte.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] LVL_OPEN   = 8'hFF;
  localparam logic [BYTE_W-1:0] LVL_WRLOCK = 8'hFE;
  localparam logic [BYTE_W-1:0] LVL_LOCKED = 8'hFC;

  localparam logic [BYTE_W-1:0] ST_OK      = 8'h00;
  localparam logic [BYTE_W-1:0] ST_WRITE   = 8'h03;
  localparam logic [BYTE_W-1:0] ST_ADDR    = 8'h08;
  localparam logic [BYTE_W-1:0] ST_VENDOR  = 8'h0B;
  localparam logic [BYTE_W-1:0] ST_UNKNOWN = 8'h0E;

  typedef enum logic [2:0] {
    OPC_MEM     = 3'd0,
    OPC_FUSE    = 3'd1,
    OPC_BOOTCFG = 3'd2,
    OPC_SECBYTE = 3'd3,
    OPC_INFO    = 3'd4,
    OPC_BLKERS  = 3'd5,
    OPC_BLANK   = 3'd6,
    OPC_RSVD    = 3'd7
  } op_class_e;

  // Rank of a level: 0 open, 1 write-locked, 2 fully locked, 3 illegal.
  function automatic logic [1:0] lvl_rank(input logic [BYTE_W-1:0] v);
    case (v)
      LVL_OPEN:   lvl_rank = 2'd0;
      LVL_WRLOCK: lvl_rank = 2'd1;
      LVL_LOCKED: lvl_rank = 2'd2;
      default:    lvl_rank = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/sec_gate_policy.sv
module sec_gate_policy
  import sec_gate_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          valid,
  input  op_class_e     cls,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] level,
  output logic          allow,
  output logic [DW-1:0] status
);

  logic [1:0] cur_rank;
  logic [1:0] new_rank;

  assign cur_rank = lvl_rank(level);
  assign new_rank = lvl_rank(wdata);

  always_comb begin
    allow  = 1'b0;
    status = ST_OK;
    if (valid) begin
      allow = 1'b1;
      case (cls)
        OPC_MEM, OPC_FUSE: begin
          if (wr && cur_rank != 2'd0) begin
            allow  = 1'b0;
            status = ST_WRITE;
          end else if (!wr && cur_rank >= 2'd2) begin
            allow  = 1'b0;
            status = ST_VENDOR;
          end
        end
        OPC_BOOTCFG: begin
          if (sel == 2'd3) begin
            allow  = 1'b0;
            status = ST_ADDR;
          end
        end
        OPC_SECBYTE: begin
          if (wr && (new_rank == 2'd3 || new_rank <= cur_rank)) begin
            allow  = 1'b0;
            status = ST_WRITE;
          end
        end
        OPC_INFO: begin
          if (wr) begin
            allow  = 1'b0;
            status = ST_WRITE;
          end
        end
        OPC_BLKERS: begin
          if (cur_rank != 2'd0) begin
            allow  = 1'b0;
            status = ST_WRITE;
          end
        end
        OPC_BLANK: ;
        default: begin
          allow  = 1'b0;
          status = ST_UNKNOWN;
        end
      endcase
    end
  end

endmodule

// File: rtl/sec_gate_store.sv
module sec_gate_store
  import sec_gate_pkg::*;
#(
  parameter int              DW       = BYTE_W,
  parameter logic [DW-1:0]   BSB_INIT = 8'hFF,
  parameter logic [DW-1:0]   SBV_INIT = 8'hFC,
  parameter logic [DW-1:0]   EB_INIT  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase,
  input  logic          sec_we,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sec_q,
  output logic [DW-1:0] bsb_q,
  output logic [DW-1:0] sbv_q,
  output logic [DW-1:0] eb_q
);

  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= LVL_OPEN;
      bsb_q <= BSB_INIT;
      sbv_q <= SBV_INIT;
      eb_q  <= EB_INIT;
    end else begin
      if (erase) begin
        sec_q <= LVL_OPEN;
        bsb_q <= ERASED;
        sbv_q <= ERASED;
      end else begin
        if (sec_we)                     sec_q <= wdata;
        if (cfg_we && cfg_sel == 2'd0)  bsb_q <= wdata;
        if (cfg_we && cfg_sel == 2'd1)  sbv_q <= wdata;
      end
      if (cfg_we && cfg_sel == 2'd2)    eb_q  <= wdata;
    end
  end

  // R2: level only rises between erases
  p_level_rises_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(erase)) |-> lvl_rank(sec_q) >= lvl_rank($past(sec_q)));

  // R2: level always holds a legal encoding
  p_level_legal_r2: assert property (@(posedge clk) disable iff (rst)
    lvl_rank(sec_q) != 2'd3);

  // R8: erase clears level, boot status and boot vector
  p_erase_clears_r8: assert property (@(posedge clk) disable iff (rst)
    erase |=> (sec_q == LVL_OPEN && bsb_q == ERASED && sbv_q == ERASED));

  // R8: spare byte untouched by erase alone
  p_spare_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (erase && !cfg_we) |=> $stable(eb_q));

endmodule

// File: rtl/sec_gate.sv
module sec_gate
  import sec_gate_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_class,
  input  logic          req_write,
  input  logic [1:0]    req_sel,
  input  logic [DW-1:0] req_wdata,
  input  logic          erase_all,
  output logic          allow,
  output logic [DW-1:0] status,
  output logic [DW-1:0] rdata
);

  op_class_e     cls;
  logic [DW-1:0] sec_q, bsb_q, sbv_q, eb_q;
  logic          sec_we, cfg_we;

  assign cls = op_class_e'(req_class);

  sec_gate_policy #(.DW(DW)) u_policy (
    .valid (req_valid),
    .cls   (cls),
    .wr    (req_write),
    .sel   (req_sel),
    .wdata (req_wdata),
    .level (sec_q),
    .allow (allow),
    .status(status)
  );

  assign sec_we = allow && req_write && cls == OPC_SECBYTE;
  assign cfg_we = allow && req_write && cls == OPC_BOOTCFG;

  sec_gate_store #(.DW(DW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .erase  (erase_all),
    .sec_we (sec_we),
    .cfg_we (cfg_we),
    .cfg_sel(req_sel),
    .wdata  (req_wdata),
    .sec_q  (sec_q),
    .bsb_q  (bsb_q),
    .sbv_q  (sbv_q),
    .eb_q   (eb_q)
  );

  always_comb begin
    rdata = '0;
    if (allow && !req_write) begin
      if (cls == OPC_SECBYTE) rdata = sec_q;
      else if (cls == OPC_BOOTCFG) begin
        case (req_sel)
          2'd0:    rdata = bsb_q;
          2'd1:    rdata = sbv_q;
          default: rdata = eb_q;
        endcase
      end
    end
  end

  // R4: fully locked level never lets an array or fuse access through
  p_locked_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sec_q == LVL_LOCKED && (cls == OPC_MEM || cls == OPC_FUSE)) |-> !allow);

  // R5: block erase only at the open level
  p_blkerase_open_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cls == OPC_BLKERS && allow) |-> sec_q == LVL_OPEN);

  // R11: refusals carry a non-zero code, grants carry 00h
  p_status_code_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (allow == (status == ST_OK)));

  // R11: refused protection write leaves level unchanged
  p_refused_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && cls == OPC_SECBYTE && !allow && !erase_all) |=> $stable(sec_q));

endmodule

// File: tb/sec_gate_bench.sv
module sec_gate_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [2:0] req_class;
  logic       req_write;
  logic [1:0] req_sel;
  logic [7:0] req_wdata;
  logic       erase_all;
  logic       allow;
  logic [7:0] status;
  logic [7:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic       s_allow;
  logic [7:0] s_status;
  logic [7:0] s_rdata;

  always #5 clk = ~clk;

  sec_gate u_sec_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .erase_all(erase_all), .allow(allow), .status(status), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Offer one operation at a negedge, sample, let one edge pass.
  task automatic op(input logic [2:0] c, input logic w, input logic [1:0] s,
                    input logic [7:0] d, input logic er);
    req_valid = 1'b1; req_class = c; req_write = w; req_sel = s;
    req_wdata = d; erase_all = er;
    #2;
    s_allow = allow; s_status = status; s_rdata = rdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; erase_all = 1'b0; req_write = 1'b0; req_wdata = 8'h00;
  endtask

  task automatic expect_op(input string tag, input logic [2:0] c, input logic w,
                           input logic [7:0] exp_status);
    op(c, w, 2'd0, 8'h00, 1'b0);
    check(tag, {7'd0, s_allow}, {7'd0, exp_status == 8'h00});
    check(tag, s_status, exp_status);
  endtask

  task automatic read_cfg(input string tag, input logic [2:0] c, input logic [1:0] s,
                          input logic [7:0] exp);
    op(c, 1'b0, s, 8'h00, 1'b0);
    check(tag, s_rdata, exp);
  endtask

  task automatic t_reset;
    read_cfg("R1 level", 3'd3, 2'd0, 8'hFF);
    read_cfg("R1 boot status", 3'd2, 2'd0, 8'hFF);
    read_cfg("R1 boot vector", 3'd2, 2'd1, 8'hFC);
    read_cfg("R1 spare", 3'd2, 2'd2, 8'hFF);
    #2;
    check("R1 idle allow", {7'd0, allow}, 8'h00);
    check("R1 idle status", status, 8'h00);
  endtask

  task automatic t_open;
    expect_op("R3 open mem write", 3'd0, 1'b1, 8'h00);
    expect_op("R3 open fuse read", 3'd1, 1'b0, 8'h00);
    expect_op("R5 open blk erase", 3'd5, 1'b1, 8'h00);
    expect_op("R7 info write", 3'd4, 1'b1, 8'h03);
    expect_op("R7 info read", 3'd4, 1'b0, 8'h00);
    expect_op("R10 reserved", 3'd7, 1'b0, 8'h0E);
    op(3'd2, 1'b0, 2'd3, 8'h00, 1'b0);
    check("R9 sel3 status", s_status, 8'h08);
    op(3'd3, 1'b1, 2'd0, 8'h55, 1'b0);
    check("R2 illegal value", s_status, 8'h03);
    op(3'd3, 1'b1, 2'd0, 8'hFF, 1'b0);
    check("R2 same level", s_status, 8'h03);
    read_cfg("R2 level kept", 3'd3, 2'd0, 8'hFF);
  endtask

  task automatic t_wrlock;
    op(3'd3, 1'b1, 2'd0, 8'hFE, 1'b0);
    check("R2 raise to FE", s_status, 8'h00);
    read_cfg("R11 level FE", 3'd3, 2'd0, 8'hFE);
    expect_op("R3 wp mem write", 3'd0, 1'b1, 8'h03);
    expect_op("R3 wp mem read", 3'd0, 1'b0, 8'h00);
    expect_op("R3 wp fuse write", 3'd1, 1'b1, 8'h03);
    expect_op("R5 wp blk erase", 3'd5, 1'b1, 8'h03);
    expect_op("R6 wp blank", 3'd6, 1'b0, 8'h00);
    op(3'd2, 1'b1, 2'd2, 8'h5A, 1'b0);
    check("R6 wp cfg write", s_status, 8'h00);
    read_cfg("R6 spare readback", 3'd2, 2'd2, 8'h5A);
    op(3'd3, 1'b1, 2'd0, 8'hFF, 1'b0);
    check("R2 lower refused", s_status, 8'h03);
    read_cfg("R2 still FE", 3'd3, 2'd0, 8'hFE);
  endtask

  task automatic t_locked;
    op(3'd3, 1'b1, 2'd0, 8'hFC, 1'b0);
    check("R2 raise to FC", s_status, 8'h00);
    read_cfg("R9 level FC", 3'd3, 2'd0, 8'hFC);
    expect_op("R4 mem read", 3'd0, 1'b0, 8'h0B);
    expect_op("R4 mem write", 3'd0, 1'b1, 8'h03);
    expect_op("R4 fuse read", 3'd1, 1'b0, 8'h0B);
    expect_op("R5 locked blk erase", 3'd5, 1'b1, 8'h03);
    expect_op("R6 locked blank", 3'd6, 1'b0, 8'h00);
    expect_op("R7 locked info read", 3'd4, 1'b0, 8'h00);
    op(3'd3, 1'b1, 2'd0, 8'hFC, 1'b0);
    check("R2 no higher level", s_status, 8'h03);
    op(3'd2, 1'b1, 2'd0, 8'h12, 1'b0);
    check("R6 locked cfg write", s_status, 8'h00);
    read_cfg("R6 boot status readback", 3'd2, 2'd0, 8'h12);
  endtask

  task automatic t_erase;
    op(3'd6, 1'b0, 2'd0, 8'h00, 1'b1);
    read_cfg("R8 level FF", 3'd3, 2'd0, 8'hFF);
    read_cfg("R8 boot status FF", 3'd2, 2'd0, 8'hFF);
    read_cfg("R8 boot vector FF", 3'd2, 2'd1, 8'hFF);
    read_cfg("R8 spare kept", 3'd2, 2'd2, 8'h5A);
  endtask

  task automatic t_collide;
    op(3'd3, 1'b1, 2'd0, 8'hFE, 1'b0);
    op(3'd3, 1'b1, 2'd0, 8'hFC, 1'b1);
    check("R8 write granted", s_status, 8'h00);
    read_cfg("R8 erase beats level write", 3'd3, 2'd0, 8'hFF);
    op(3'd2, 1'b1, 2'd1, 8'h33, 1'b1);
    read_cfg("R8 erase beats vector write", 3'd2, 2'd1, 8'hFF);
    op(3'd2, 1'b1, 2'd2, 8'h77, 1'b1);
    read_cfg("R8 spare write survives", 3'd2, 2'd2, 8'h77);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_class = 3'd0; req_write = 1'b0;
    req_sel = 2'd0; req_wdata = 8'h00; erase_all = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_open();
    t_wrlock();
    t_locked();
    t_erase();
    t_collide();
    finish_run();
  end

endmodule